// File: doc/BRIEF.md
# CAN Bit Timing Calculator

This block works out the bit timing settings for a CAN controller. It takes the frequency of the clock that drives the controller and the bitrate the bus should run at. It returns a prescaler and the lengths of the two phase segments, already encoded as value minus one, or it raises an error flag when no exact setting exists. A one-cycle `start` pulse launches a calculation. A one-cycle `done` pulse ends it, and the result holds until the next calculation completes.

The engine first sets an upper limit on time quanta per bit. The limit is 10 at fast bitrates and 17 at slower ones. It then searches downward for the largest quanta count that divides the clock-to-bitrate ratio exactly, and derives the prescaler from that count. Next it splits the quanta between the two segments so that the sample point lands near seven eighths of the bit. As a last step it confirms that the chosen settings reproduce the requested bitrate exactly. Every division uses one shared restoring shift-subtract divider, which takes 32 cycles per operation.

Top module: `can_bit_timing_calc`

## Requirements
- R1: After reset, `done` and `error` are 0, and `presc_m1`, `seg1_m1`, `seg2_m1` and `sjw_m1` are all 0.
- R2: The quanta-per-bit ceiling is 10 when `bitrate` is 1,000,000 or more, and 17 otherwise. The search begins with the segment sum equal to the ceiling minus one.
- R3: Let the ratio be floor(`clk_hz`/`bitrate`). The engine lowers the segment sum one step at a time until (1+sum) divides the ratio exactly. The prescaler is then the ratio divided by (1+sum).
- R4: When the divisibility test fails at a segment sum of 2 or less, the calculation ends with `error`=1.
- R5: A prescaler outside 1..1024 ends the calculation with `error`=1. Exactly 1024 is accepted.
- R6: Segment 1 is first tried as ((7*sum-1)+4)/8, and segment 2 is sum minus segment 1. That candidate is rejected when floor(1000*(1+seg1)/(1+sum)) exceeds 900, or when segment 1 falls outside 1..16 or segment 2 outside 1..8. In that case (7*sum-1)/8 is used instead. If the second candidate is also out of range, the result is an error. A sample point of exactly 900 keeps the first candidate.
- R7: Unless floor(`clk_hz`/(prescaler*(1+sum))) equals `bitrate` exactly, the result is an error.
- R8: A successful result drives prescaler-1 on `presc_m1` (10 bits), segment1-1 on `seg1_m1` (4 bits), segment2-1 on `seg2_m1` (3 bits) and 0 on `sjw_m1` (one quantum), with `error`=0. Any error result drives all four fields to 0.
- R9: A `bitrate` of 0 ends the calculation with `error`=1 and `done` in the cycle right after `start`.
- R10: `done` is high for exactly one cycle per calculation. `presc_m1`, `seg1_m1`, `seg2_m1` and `error` change only in a cycle where `done` is high.
- R11: A `start` pulse that arrives while a calculation is running is ignored. The running calculation finishes with its own inputs and gives only one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| clk_hz | input | 32 | Peripheral clock frequency in Hz |
| bitrate | input | 32 | Target bitrate in bit/s |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last calculation found no valid setting |
| presc_m1 | output | 10 | Prescaler minus one |
| seg1_m1 | output | 4 | Segment 1 length minus one |
| seg2_m1 | output | 3 | Segment 2 length minus one |
| sjw_m1 | output | 2 | Resync jump width minus one (always 0) |

## Verification
The bench picks ratios that drive the search into each exit. In one case the quanta search has to walk down six steps, and a design that stopped early or stepped wrongly would return a different prescaler. In another the first rounding gives a 916 per-mille sample point and must fall back, while a sample point of exactly 900 must not fall back. An off-by-one in the comparison would swap the segment lengths in one of those two cases. The bitrate pair 1,000,000 and 999,999 tests the ceiling threshold, and the prescaler cases 1024, 1250 and 0 test the range check. A case where the division is exact but the bitrate is not, plus a ratio that is a prime number, test the two late error exits that a careless design would report as a success.

// File: rtl/can_bit_timing_calc.sv
module can_bit_timing_calc #(
  parameter int FAST_RATE = 1_000_000,
  parameter int MAXQ_FAST = 10,
  parameter int MAXQ_SLOW = 17,
  parameter int MAX_SEG1  = 16,
  parameter int MAX_SEG2  = 8,
  parameter int MAX_PRESC = 1024,
  parameter int SP_LIMIT  = 900
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] clk_hz,
  input  logic [31:0] bitrate,
  output logic        done,
  output logic        error,
  output logic [9:0]  presc_m1,
  output logic [3:0]  seg1_m1,
  output logic [2:0]  seg2_m1,
  output logic [1:0]  sjw_m1
);
  localparam logic [5:0] DIV_STEPS = 6'd32;
  localparam logic [4:0] SUM_FAST  = 5'(MAXQ_FAST - 1);
  localparam logic [4:0] SUM_SLOW  = 5'(MAXQ_SLOW - 1);

  typedef enum logic [2:0] {IDLE, DIV, EV_RATIO, EV_QUANT, EV_CHECK} st_t;
  st_t st, ret;

  logic [31:0] clk_r, br_r, ratio, quo, dvs, rem, presc_r;
  logic [5:0]  cnt;
  logic [4:0]  sum, seg1_r, seg2_r;

  assign sjw_m1 = 2'd0;

  logic [32:0] sh, rem_n;
  logic        ge;
  assign sh    = {rem, quo[31]};
  assign ge    = sh >= {1'b0, dvs};
  assign rem_n = ge ? sh - {1'b0, dvs} : sh;

  logic [7:0]  s7;
  logic [4:0]  a1, a2, b1, b2, sum_init;
  logic [15:0] a_lhs, rhs;
  logic        a_ok, b_ok;
  assign s7       = 8'(sum) * 8'd7;
  assign a1       = 5'((s7 + 8'd3) >> 3);
  assign b1       = 5'((s7 - 8'd1) >> 3);
  assign a2       = sum - a1;
  assign b2       = sum - b1;
  assign a_lhs    = 16'd1000 * (16'd1 + 16'(a1));
  assign rhs      = 16'(SP_LIMIT + 1) * (16'd1 + 16'(sum));
  assign a_ok     = (a1 >= 5'd1) && (a1 <= 5'(MAX_SEG1)) && (a2 >= 5'd1) && (a2 <= 5'(MAX_SEG2)) && (a_lhs < rhs);
  assign b_ok     = (b1 >= 5'd1) && (b1 <= 5'(MAX_SEG1)) && (b2 >= 5'd1) && (b2 <= 5'(MAX_SEG2));
  assign sum_init = (br_r >= 32'(FAST_RATE)) ? SUM_FAST : SUM_SLOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ret <= IDLE;
      clk_r <= '0; br_r <= '0; ratio <= '0; quo <= '0; dvs <= '0; rem <= '0; presc_r <= '0;
      cnt <= '0; sum <= '0; seg1_r <= '0; seg2_r <= '0;
      done <= 1'b0; error <= 1'b0;
      presc_m1 <= '0; seg1_m1 <= '0; seg2_m1 <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          clk_r <= clk_hz;
          br_r  <= bitrate;
          if (bitrate == 32'd0) begin
            done <= 1'b1; error <= 1'b1;
            presc_m1 <= '0; seg1_m1 <= '0; seg2_m1 <= '0;
          end else begin
            quo <= clk_hz; rem <= '0; dvs <= bitrate; cnt <= DIV_STEPS;
            ret <= EV_RATIO; st <= DIV;
          end
        end
        DIV: begin
          quo <= {quo[30:0], ge};
          rem <= rem_n[31:0];
          cnt <= cnt - 6'd1;
          if (cnt == 6'd1) st <= ret;
        end
        EV_RATIO: begin
          ratio <= quo;
          sum   <= sum_init;
          dvs   <= 32'(sum_init) + 32'd1;
          rem   <= '0; cnt <= DIV_STEPS;
          ret   <= EV_QUANT; st <= DIV;
        end
        EV_QUANT: begin
          if (rem == 32'd0) begin
            presc_r <= quo;
            if (quo < 32'd1 || quo > 32'(MAX_PRESC) || !(a_ok || b_ok)) begin
              st <= IDLE; done <= 1'b1; error <= 1'b1;
              presc_m1 <= '0; seg1_m1 <= '0; seg2_m1 <= '0;
            end else begin
              seg1_r <= a_ok ? a1 : b1;
              seg2_r <= a_ok ? a2 : b2;
              quo <= clk_r; dvs <= ratio; rem <= '0; cnt <= DIV_STEPS;
              ret <= EV_CHECK; st <= DIV;
            end
          end else if (sum <= 5'd2) begin
            st <= IDLE; done <= 1'b1; error <= 1'b1;
            presc_m1 <= '0; seg1_m1 <= '0; seg2_m1 <= '0;
          end else begin
            sum <= sum - 5'd1;
            quo <= ratio; dvs <= 32'(sum); rem <= '0; cnt <= DIV_STEPS;
            ret <= EV_QUANT; st <= DIV;
          end
        end
        EV_CHECK: begin
          st <= IDLE; done <= 1'b1;
          if (quo == br_r) begin
            error    <= 1'b0;
            presc_m1 <= 10'(presc_r - 32'd1);
            seg1_m1  <= 4'(seg1_r - 5'd1);
            seg2_m1  <= 3'(seg2_r - 5'd1);
          end else begin
            error <= 1'b1;
            presc_m1 <= '0; seg1_m1 <= '0; seg2_m1 <= '0;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(presc_m1) && $stable(seg1_m1) && $stable(seg2_m1) && $stable(error)));

  // R9
  zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && start && bitrate == 32'd0) |=> (done && error));

  // R6
  sample_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (32'd1000 * (32'(seg1_m1) + 32'd2) < 32'(SP_LIMIT + 1) * (32'(seg1_m1) + 32'(seg2_m1) + 32'd3)));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (presc_m1 == 10'd0 && seg1_m1 == 4'd0 && seg2_m1 == 3'd0));

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DIV && start) |=> (st != IDLE || done));
endmodule

// File: tb/can_bit_timing_calc_tb.sv
module can_bit_timing_calc_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] clk_hz = '0, bitrate = '0;
  logic done, error;
  logic [9:0] presc_m1;
  logic [3:0] seg1_m1;
  logic [2:0] seg2_m1;
  logic [1:0] sjw_m1;
  int checks = 0, fails = 0, dones = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  can_bit_timing_calc u_dut (.clk(clk), .rst_n(rst_n), .start(start), .clk_hz(clk_hz),
    .bitrate(bitrate), .done(done), .error(error), .presc_m1(presc_m1),
    .seg1_m1(seg1_m1), .seg2_m1(seg2_m1), .sjw_m1(sjw_m1));

  always @(negedge clk) if (done) dones++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic calc(input logic [31:0] f, input logic [31:0] b);
    int n;
    @(negedge clk);
    clk_hz = f; bitrate = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "done seen", done, 1);
  endtask

  task automatic expect_ok(input string req, input int p, input int s1, input int s2);
    chk(error == 1'b0, req, error, 0);
    chk(presc_m1 == 10'(p), req, presc_m1, p);
    chk(seg1_m1 == 4'(s1), req, seg1_m1, s1);
    chk(seg2_m1 == 3'(s2), req, seg2_m1, s2);
    chk(sjw_m1 == 2'd0, {req, " R8 sjw"}, sjw_m1, 0);
  endtask

  task automatic expect_err(input string req);
    chk(error == 1'b1, req, error, 1);
    chk(presc_m1 == 10'd0 && seg1_m1 == 4'd0 && seg2_m1 == 3'd0, {req, " R8 zero fields"},
        {presc_m1, seg1_m1, seg2_m1}, 0);
  endtask

  task automatic t_reset;
    chk(done == 1'b0 && error == 1'b0, "R1 flags", {done, error}, 0);
    chk(presc_m1 == 0 && seg1_m1 == 0 && seg2_m1 == 0 && sjw_m1 == 0, "R1 fields",
        {presc_m1, seg1_m1, seg2_m1, sjw_m1}, 0);
  endtask

  task automatic t_fast_limit;
    calc(32'd36_000_000, 32'd1_000_000);
    expect_ok("R2 R8 36MHz/1M", 3, 6, 0);
    calc(32'd80_000_000, 32'd1_000_000);
    expect_ok("R2 R6 sp exactly 900", 7, 7, 0);
  endtask

  task automatic t_slow_limit;
    calc(32'd79_999_920, 32'd999_999);
    expect_ok("R2 999999 uses 17", 4, 12, 1);
    calc(32'd40_000_000, 32'd500_000);
    expect_ok("R2 40MHz/500k", 4, 12, 1);
  endtask

  task automatic t_search_fallback;
    calc(32'd36_000_000, 32'd500_000);
    expect_ok("R3 R6 deep search and truncation", 5, 8, 1);
  endtask

  task automatic t_no_quanta;
    calc(32'd19_000_000, 32'd1_000_000);
    expect_err("R4 prime ratio");
  endtask

  task automatic t_presc_range;
    calc(32'd17_408_000, 32'd1000);
    expect_ok("R5 prescaler 1024", 1023, 13, 1);
    calc(32'd80_000_000, 32'd4000);
    expect_err("R5 prescaler 1250");
    calc(32'd1000, 32'd2000);
    expect_err("R5 prescaler 0");
  endtask

  task automatic t_inexact;
    calc(32'd100, 32'd30);
    expect_err("R7 inexact bitrate");
  endtask

  task automatic t_zero_rate;
    @(negedge clk);
    clk_hz = 32'd36_000_000; bitrate = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R9 immediate done", done, 1);
    expect_err("R9 zero bitrate");
  endtask

  task automatic t_pulse_hold;
    int d0;
    calc(32'd36_000_000, 32'd1_000_000);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    repeat (20) @(negedge clk);
    chk(done == 1'b0, "R10 no extra done", done, 0);
    expect_ok("R10 fields held", 3, 6, 0);
    d0 = dones;
    repeat (5) @(negedge clk);
    chk(dones == d0, "R10 done count", dones, d0);
  endtask

  task automatic t_busy_start;
    int d0, n;
    d0 = dones;
    @(negedge clk);
    clk_hz = 32'd36_000_000; bitrate = 32'd500_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    clk_hz = 32'd80_000_000; bitrate = 32'd1_000_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    expect_ok("R11 busy start ignored", 5, 8, 1);
    repeat (600) @(negedge clk);
    chk(dones == d0 + 1, "R11 single done", dones, d0 + 1);
    expect_ok("R11 result unchanged", 5, 8, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fast_limit();
    t_slow_limit();
    t_search_fallback();
    t_no_quanta();
    t_presc_range();
    t_inexact();
    t_zero_rate();
    t_pulse_hold();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule